// File: doc/BRIEF.md
# Fused multiply-add NaN result selector

This block sits beside the special-case path of a fused multiply-add unit computing (a*b)+c. When at least one operand is a NaN, or when the two multiplicands are an infinity and a zero, something has to choose the result. This block receives a two-bit class for each of the three operands and an infinity-times-zero indication. It returns a two-bit choice: 0 picks a, 1 picks b, 2 picks c and 3 picks the default NaN. It also raises an invalid flag and a separate invalid-multiply flag for the infinity-times-zero case. The operand words pass through the same selection. A picked signaling NaN leaves the block quieted, and a default-NaN pick leaves as a constant word.

A three-bit mode input chooses among six selection policies and one fallback policy. The modes differ in two ways: how infinity-times-zero is handled (forced to the default NaN, forced to c, or only under a condition), and the priority order among the operands. One mode also reads a use-first input, which reverses its scan order. All inputs are captured on a cycle with `in_valid` high. The results appear on the next cycle and hold until the next capture.

Top module: `fma_nan_select`

States: `ST_IDLE` (no fresh result, `out_valid` low) and `ST_SHOW` (result captured last cycle, `out_valid` high). Transitions: any state goes to `ST_SHOW` on a cycle with `in_valid` high, and goes to `ST_IDLE` on a cycle with `in_valid` low.

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. Mode, classes, flags and data are sampled only when `in_valid` is high. While `in_valid` is low, every result output holds its value.
- R2: In mode 0, when infinity-times-zero is set and c is a quiet NaN, the pick is 3, and both `out_invalid` and `out_invalid_imz` are 1.
- R3: Otherwise in mode 0, the pick follows this order: c signaling, then a signaling, then b signaling, then c quiet, then a quiet, otherwise b.
- R4: In mode 1, infinity-times-zero gives pick 3 with both flags raised. Otherwise the pick follows this order: a signaling, b signaling, c signaling, a quiet, b quiet, otherwise c.
- R5: In mode 2, infinity-times-zero gives pick 2 with both flags raised. Otherwise the pick follows this order: c signaling, a signaling, b signaling, c quiet, a quiet, otherwise b.
- R6: In mode 3, infinity-times-zero gives pick 2 with both flags raised. Otherwise the pick is a if a is any NaN, else c if c is any NaN, else b.
- R7: In mode 4, the pick is always 3. `out_invalid_imz` equals the infinity-times-zero input.
- R8: In mode 5, infinity-times-zero gives pick 2 with both flags raised. Otherwise, with use-first set, the pick is the first NaN in the order a, b, c (c if none is a NaN). With use-first clear, the pick is the first NaN in the order c, b, a (a if none is a NaN).
- R9: Modes 6 and 7 ignore infinity-times-zero and never raise `out_invalid_imz`. The pick is the first NaN in the order a, b, c, and c if none is a NaN.
- R10: `out_invalid` is 1 when any operand class is signaling or when `out_invalid_imz` is raised; otherwise it is 0. Class codes are 0 for not a NaN, 1 for quiet NaN, 2 for signaling NaN, and 3 for reserved (treated as not a NaN).
- R11: `out_data` is the picked operand word. If that operand's class is signaling, the top fraction bit (bit MANT_W-1, bit 22 by default) is forced to 1. Pick 3 gives the default NaN word: sign 0, exponent all ones, only the top fraction bit set (0x7FC00000 by default).
- R12: After reset, `out_valid`, `out_pick`, `out_data`, `out_invalid` and `out_invalid_imz` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Capture strobe for all inputs |
| in_mode | input | 3 | Selection policy, 0 to 7 |
| in_use_first | input | 1 | Scan-order select used by mode 5 |
| in_infzero | input | 1 | Multiplicands are infinity and zero |
| in_cls_a | input | 2 | Class of operand a |
| in_cls_b | input | 2 | Class of operand b |
| in_cls_c | input | 2 | Class of operand c |
| in_a | input | FW | Operand a word |
| in_b | input | FW | Operand b word |
| in_c | input | FW | Operand c word |
| out_valid | output | 1 | Fresh result this cycle |
| out_pick | output | 2 | 0 a, 1 b, 2 c, 3 default NaN |
| out_data | output | FW | Selected, quieted result word |
| out_invalid | output | 1 | Invalid-operation flag |
| out_invalid_imz | output | 1 | Invalid flag for infinity times zero |

## Verification
The hardest behaviour to reach is mode 0 with infinity-times-zero set. There, the default-NaN result and the multiply flag appear only when c is quiet. A signaling c must instead win through the normal order, and the only flag left is the one raised by the signaling operand. The stimulus sweeps every combination of mode, use-first, infinity-times-zero and the three operand classes (including the reserved class), so each such pairing is reached. A final phase changes every input while `in_valid` is low and confirms that the outputs do not move.

// File: rtl/fma_nan_pkg.sv
package fma_nan_pkg;
    typedef enum logic [1:0] {
        CLS_NUM  = 2'd0,
        CLS_QNAN = 2'd1,
        CLS_SNAN = 2'd2,
        CLS_RSVD = 2'd3
    } opcls_t;

    typedef enum logic [1:0] {
        PK_A   = 2'd0,
        PK_B   = 2'd1,
        PK_C   = 2'd2,
        PK_DEF = 2'd3
    } pick_t;

    typedef enum logic [2:0] {
        MD_C_SIG_FIRST = 3'd0,
        MD_ABC_LEGACY  = 3'd1,
        MD_CAB_REVISED = 3'd2,
        MD_A_C_B       = 3'd3,
        MD_ALWAYS_DEF  = 3'd4,
        MD_SWITCHABLE  = 3'd5,
        MD_PLAIN_6     = 3'd6,
        MD_PLAIN_7     = 3'd7
    } sel_mode_t;
endpackage

// File: rtl/fma_nan_policy.sv
module fma_nan_policy
    import fma_nan_pkg::*;
(
    input  logic [2:0] mode,
    input  logic       use_first,
    input  logic       infzero,
    input  logic [1:0] cls_a,
    input  logic [1:0] cls_b,
    input  logic [1:0] cls_c,
    output logic [1:0] pick,
    output logic       imz,
    output logic       invalid
);
    logic sa, sb, sc, qa, qb, qc, na, nb, nc;
    pick_t     pk;
    sel_mode_t md;

    always_comb begin
        sa = (cls_a == CLS_SNAN);
        sb = (cls_b == CLS_SNAN);
        sc = (cls_c == CLS_SNAN);
        qa = (cls_a == CLS_QNAN);
        qb = (cls_b == CLS_QNAN);
        qc = (cls_c == CLS_QNAN);
        na = sa | qa;
        nb = sb | qb;
        nc = sc | qc;
        md = sel_mode_t'(mode);
    end

    always_comb begin
        pk  = PK_B;
        imz = 1'b0;
        unique case (md)
            MD_C_SIG_FIRST: begin
                if (infzero && qc) begin
                    imz = 1'b1;
                    pk  = PK_DEF;
                end
                else if (sc) pk = PK_C;
                else if (sa) pk = PK_A;
                else if (sb) pk = PK_B;
                else if (qc) pk = PK_C;
                else if (qa) pk = PK_A;
                else         pk = PK_B;
            end
            MD_ABC_LEGACY: begin
                if (infzero) begin
                    imz = 1'b1;
                    pk  = PK_DEF;
                end
                else if (sa) pk = PK_A;
                else if (sb) pk = PK_B;
                else if (sc) pk = PK_C;
                else if (qa) pk = PK_A;
                else if (qb) pk = PK_B;
                else         pk = PK_C;
            end
            MD_CAB_REVISED: begin
                if (infzero) begin
                    imz = 1'b1;
                    pk  = PK_C;
                end
                else if (sc) pk = PK_C;
                else if (sa) pk = PK_A;
                else if (sb) pk = PK_B;
                else if (qc) pk = PK_C;
                else if (qa) pk = PK_A;
                else         pk = PK_B;
            end
            MD_A_C_B: begin
                if (infzero) begin
                    imz = 1'b1;
                    pk  = PK_C;
                end
                else if (na) pk = PK_A;
                else if (nc) pk = PK_C;
                else         pk = PK_B;
            end
            MD_ALWAYS_DEF: begin
                imz = infzero;
                pk  = PK_DEF;
            end
            MD_SWITCHABLE: begin
                if (infzero) begin
                    imz = 1'b1;
                    pk  = PK_C;
                end
                else if (use_first) begin
                    if (na)      pk = PK_A;
                    else if (nb) pk = PK_B;
                    else         pk = PK_C;
                end
                else begin
                    if (nc)      pk = PK_C;
                    else if (nb) pk = PK_B;
                    else         pk = PK_A;
                end
            end
            default: begin
                if (na)      pk = PK_A;
                else if (nb) pk = PK_B;
                else         pk = PK_C;
            end
        endcase
    end

    assign pick    = pk;
    assign invalid = imz | sa | sb | sc;
endmodule

// File: rtl/fma_nan_quiet_mux.sv
module fma_nan_quiet_mux #(
    parameter int FW     = 32,
    parameter int MANT_W = 23
) (
    input  logic [2:0][FW-1:0] ops,
    input  logic [2:0]         is_snan,
    input  logic [1:0]         pick,
    output logic [FW-1:0]      data
);
    localparam int EXP_W = FW - MANT_W - 1;
    localparam logic [FW-1:0] QMASK   = FW'(1) << (MANT_W - 1);
    localparam logic [FW-1:0] DEF_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MANT_W-1){1'b0}}};

    logic [2:0][FW-1:0] quieted;

    for (genvar i = 0; i < 3; i++) begin : g_quiet
        assign quieted[i] = is_snan[i] ? (ops[i] | QMASK) : ops[i];
    end

    always_comb begin
        unique case (pick)
            2'd0:    data = quieted[0];
            2'd1:    data = quieted[1];
            2'd2:    data = quieted[2];
            default: data = DEF_NAN;
        endcase
    end
endmodule

// File: rtl/fma_nan_select.sv
module fma_nan_select
    import fma_nan_pkg::*;
#(
    parameter int FW     = 32,
    parameter int MANT_W = 23
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [2:0]    in_mode,
    input  logic          in_use_first,
    input  logic          in_infzero,
    input  logic [1:0]    in_cls_a,
    input  logic [1:0]    in_cls_b,
    input  logic [1:0]    in_cls_c,
    input  logic [FW-1:0] in_a,
    input  logic [FW-1:0] in_b,
    input  logic [FW-1:0] in_c,
    output logic          out_valid,
    output logic [1:0]    out_pick,
    output logic [FW-1:0] out_data,
    output logic          out_invalid,
    output logic          out_invalid_imz
);
    localparam int EXP_W = FW - MANT_W - 1;
    localparam logic [FW-1:0] DEF_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MANT_W-1){1'b0}}};

    typedef enum logic {ST_IDLE = 1'b0, ST_SHOW = 1'b1} st_t;
    st_t state, state_nx;

    logic [1:0]    c_pick;
    logic          c_imz, c_inv;
    logic [FW-1:0] c_data;
    logic [2:0]    snan_vec;

    fma_nan_policy u_policy (
        .mode     (in_mode),
        .use_first(in_use_first),
        .infzero  (in_infzero),
        .cls_a    (in_cls_a),
        .cls_b    (in_cls_b),
        .cls_c    (in_cls_c),
        .pick     (c_pick),
        .imz      (c_imz),
        .invalid  (c_inv)
    );

    assign snan_vec = {in_cls_c == CLS_SNAN, in_cls_b == CLS_SNAN, in_cls_a == CLS_SNAN};

    fma_nan_quiet_mux #(.FW(FW), .MANT_W(MANT_W)) u_mux (
        .ops    ({in_c, in_b, in_a}),
        .is_snan(snan_vec),
        .pick   (c_pick),
        .data   (c_data)
    );

    always_comb begin
        unique case (state)
            ST_IDLE: state_nx = in_valid ? ST_SHOW : ST_IDLE;
            ST_SHOW: state_nx = in_valid ? ST_SHOW : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_pick        <= 2'd0;
            out_data        <= '0;
            out_invalid     <= 1'b0;
            out_invalid_imz <= 1'b0;
        end
        else if (in_valid) begin
            out_pick        <= c_pick;
            out_data        <= c_data;
            out_invalid     <= c_inv;
            out_invalid_imz <= c_imz;
        end
    end

    assign out_valid = (state == ST_SHOW);

    // R1
    a_r1_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R1
    a_r1_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_pick) && $stable(out_data)
                       && $stable(out_invalid) && $stable(out_invalid_imz)));
    // R10
    a_r10_imz_implies_inv: assert property (@(posedge clk) disable iff (!rst_n)
        out_invalid_imz |-> out_invalid);
    // R7
    a_r7_mode4_default: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 3'd4) |=> (out_pick == 2'd3));
    // R11
    a_r11_default_word: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_pick == 2'd3) |-> (out_data == DEF_NAN));
    // R9
    a_r9_plain_no_imz: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode[2:1] == 2'b11) |=> !out_invalid_imz);
endmodule

// File: tb/tb_fma_nan_select.sv
`timescale 1ns/1ps
module tb_fma_nan_select;
    localparam int FW = 32;
    localparam logic [31:0] DEFW  = 32'h7FC0_0000;
    localparam logic [31:0] QM    = 32'h0040_0000;
    localparam logic [31:0] WA    = 32'h7F81_0A0A;
    localparam logic [31:0] WB    = 32'hFF82_0B0B;
    localparam logic [31:0] WC    = 32'h7F83_0C0C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [2:0] in_mode = '0;
    logic in_use_first = 1'b0, in_infzero = 1'b0;
    logic [1:0] in_cls_a = '0, in_cls_b = '0, in_cls_c = '0;
    logic [FW-1:0] in_a = '0, in_b = '0, in_c = '0;
    logic out_valid, out_invalid, out_invalid_imz;
    logic [1:0] out_pick;
    logic [FW-1:0] out_data;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    fma_nan_select dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
        .in_use_first(in_use_first), .in_infzero(in_infzero),
        .in_cls_a(in_cls_a), .in_cls_b(in_cls_b), .in_cls_c(in_cls_c),
        .in_a(in_a), .in_b(in_b), .in_c(in_c),
        .out_valid(out_valid), .out_pick(out_pick), .out_data(out_data),
        .out_invalid(out_invalid), .out_invalid_imz(out_invalid_imz)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference selection model written from the requirement text.
    function automatic void model(int m, bit uf, bit iz, int ca, int cb, int cc,
                                  output int pk, output bit imz);
        bit sa = (ca == 2), sb = (cb == 2), sc = (cc == 2);
        bit qa = (ca == 1), qb = (cb == 1), qc = (cc == 1);
        bit na = sa || qa, nb = sb || qb, nc = sc || qc;
        imz = 0;
        case (m)
            0: if (iz && qc) begin imz = 1; pk = 3; end
               else pk = sc ? 2 : sa ? 0 : sb ? 1 : qc ? 2 : qa ? 0 : 1;
            1: if (iz) begin imz = 1; pk = 3; end
               else pk = sa ? 0 : sb ? 1 : sc ? 2 : qa ? 0 : qb ? 1 : 2;
            2: if (iz) begin imz = 1; pk = 2; end
               else pk = sc ? 2 : sa ? 0 : sb ? 1 : qc ? 2 : qa ? 0 : 1;
            3: if (iz) begin imz = 1; pk = 2; end
               else pk = na ? 0 : nc ? 2 : 1;
            4: begin imz = iz; pk = 3; end
            5: if (iz) begin imz = 1; pk = 2; end
               else if (uf) pk = na ? 0 : nb ? 1 : 2;
               else pk = nc ? 2 : nb ? 1 : 0;
            default: pk = na ? 0 : nb ? 1 : 2;
        endcase
    endfunction

    function automatic string mode_req(int m, bit iz, int cc);
        case (m)
            0: return (iz && cc == 1) ? "R2" : "R3";
            1: return "R4";
            2: return "R5";
            3: return "R6";
            4: return "R7";
            5: return "R8";
            default: return "R9";
        endcase
    endfunction

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12 valid", 64'(out_valid), 64'd0);
        check("R12 pick", 64'(out_pick), 64'd0);
        check("R12 data", 64'(out_data), 64'd0);
        check("R12 flags", 64'({out_invalid, out_invalid_imz}), 64'd0);
        rst_n = 1'b1;
        in_a = WA; in_b = WB; in_c = WC;
        @(negedge clk);
        check("R1 idle valid", 64'(out_valid), 64'd0);

        for (int m = 0; m < 8; m++)
        for (int uf = 0; uf < 2; uf++)
        for (int iz = 0; iz < 2; iz++)
        for (int ca = 0; ca < 4; ca++)
        for (int cb = 0; cb < 4; cb++)
        for (int cc = 0; cc < 4; cc++) begin
            int  pk;
            bit  imz, inv;
            logic [31:0] ew;
            string rq;
            in_mode = 3'(m); in_use_first = uf[0]; in_infzero = iz[0];
            in_cls_a = 2'(ca); in_cls_b = 2'(cb); in_cls_c = 2'(cc);
            in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            model(m, uf[0], iz[0], ca, cb, cc, pk, imz);
            inv = imz || ca == 2 || cb == 2 || cc == 2;
            case (pk)
                0: ew = (ca == 2) ? (WA | QM) : WA;
                1: ew = (cb == 2) ? (WB | QM) : WB;
                2: ew = (cc == 2) ? (WC | QM) : WC;
                default: ew = DEFW;
            endcase
            rq = mode_req(m, iz[0], cc);
            check("R1 valid after capture", 64'(out_valid), 64'd1);
            check(rq, 64'(out_pick), 64'(pk));
            check("R10 flags", 64'({out_invalid, out_invalid_imz}), 64'({inv, imz}));
            check("R11 data", 64'(out_data), 64'(ew));
        end

        // R1: inputs changed with in_valid low must not reach the outputs
        begin
            logic [1:0] p0; logic [31:0] d0; logic i0, z0;
            in_mode = 3'd1; in_use_first = 1'b0; in_infzero = 1'b0;
            in_cls_a = 2'd2; in_cls_b = 2'd0; in_cls_c = 2'd0;
            in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            p0 = out_pick; d0 = out_data; i0 = out_invalid; z0 = out_invalid_imz;
            check("R4 captured snan a", 64'(p0), 64'd0);
            in_mode = 3'd4; in_infzero = 1'b1; in_cls_a = 2'd0; in_a = 32'h1234_5678;
            @(negedge clk);
            check("R1 hold valid", 64'(out_valid), 64'd0);
            check("R1 hold pick", 64'(out_pick), 64'(p0));
            check("R1 hold data", 64'(out_data), 64'(d0));
            check("R1 hold flags", 64'({out_invalid, out_invalid_imz}), 64'({i0, z0}));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule